// File: doc/BRIEF.md
# Masked Indicator Register Unit

This unit keeps a 36-position indicator register. Position 0 is the most significant and sits on vector bit 35, so position p is vector bit 35-p. The left half holds positions 0 to 17 and the right half holds positions 18 to 35. One command may be presented per cycle. A command carries an operation code, a scope and a 36-bit operand word.

With whole scope the operand word is the mask. With half scope the mask is the 18-bit field `cmd_word[17:0]`, laid over the selected half with its top bit on the first position of that half. Write operations act only on the selected scope: load, OR-set, clear under mask and invert under mask. Two match tests decide whether the surrounding sequencer should skip or branch. The on-test asks whether every mask one finds a set indicator. The off-test asks whether every mask one finds a clear indicator.

The test verdict comes out as a registered one-cycle flag. The register value is always visible on an output.

Top module: `ind_mask_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ind_q` becomes all zeros and `hit_q` becomes 0.
- R2: Load (op 0) with whole scope replaces all 36 indicators with `cmd_word`. With half scope, load replaces only the selected half with `cmd_word[17:0]`.
- R3: Set (op 1) turns on each in-scope indicator whose mask bit is 1 and leaves every other indicator unchanged.
- R4: Clear (op 2) turns off each in-scope indicator whose mask bit is 1 and leaves every other indicator unchanged.
- R5: Invert (op 3) complements each in-scope indicator whose mask bit is 1 and leaves every other indicator unchanged.
- R6: The scope code is 0 for the whole word, 1 for the left half (positions 0 to 17, vector bits 35:18) and 2 for the right half (positions 18 to 35, vector bits 17:0). With half scope, mask bit `cmd_word[17-k]` maps to position k of the half, and the other half is never changed.
- R7: On-test (op 4) yields 1 exactly when every in-scope position with mask 1 holds a 1.
- R8: Off-test (op 5) yields 1 exactly when every in-scope position with mask 1 holds a 0.
- R9: With an all-zero mask, both the on-test and the off-test yield 1.
- R10: `hit_q` carries the test verdict in the cycle after a test command and is 0 after any other cycle. Tests leave `ind_q` unchanged.
- R11: Op codes 6 and 7 and scope code 3 are ignored: `ind_q` is unchanged and `hit_q` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Operation code (0 load, 1 set, 2 clear, 3 invert, 4 on-test, 5 off-test) |
| cmd_scope | input | 2 | 0 whole, 1 left half, 2 right half, 3 reserved |
| cmd_word | input | 36 | Operand word, or a half mask in bits 17:0 |
| ind_q | output | 36 | Indicator register, position 0 on bit 35 |
| hit_q | output | 1 | Registered test verdict |

## Verification
The bench targets the half-word mapping. If the 18-bit field landed on the wrong half, or landed bit-reversed, the wrong indicators would change and the untouched half would drift. The bench also covers zero masks, where a design that returns "no ones found" as a failure would report no skip. Reserved op and scope codes come next: a design that decoded them as whole-word or load would corrupt the register or raise a spurious hit. Finally, test commands followed by idle cycles expose a verdict that is combinational, held too long, or written back into the register.

// File: rtl/ind_mask_pkg.sv
// Shared encodings for the masked indicator register unit.
// Assumes a 3-bit operation code and a 2-bit scope code.
package ind_mask_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_SET   = 3'd1,
        OP_CLEAR = 3'd2,
        OP_FLIP  = 3'd3,
        OP_T_ON  = 3'd4,
        OP_T_OFF = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } ind_op_e;

    typedef enum logic [1:0] {
        SC_WHOLE = 2'd0,
        SC_LEFT  = 2'd1,
        SC_RIGHT = 2'd2,
        SC_RSVD  = 2'd3
    } ind_scope_e;
endpackage

// File: rtl/ind_mask_place.sv
// Places the operand over the register according to scope.
// sel_o marks the in-scope positions.
// mask_o is the operand aligned to the register and limited to sel_o.
// A reserved scope selects nothing.
// Assumes the left half is the upper HALF_W vector bits.
module ind_mask_place
    import ind_mask_pkg::*;
#(
    parameter int HALF_W = 18,
    localparam int W = 2 * HALF_W
) (
    input  ind_scope_e       scope_i,
    input  logic [W-1:0]     word_i,
    output logic [W-1:0]     sel_o,
    output logic [W-1:0]     mask_o
);
    logic whole;
    assign whole = (scope_i == SC_WHOLE);

    // One slice per half: h=1 is the left half, h=0 the right half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic in_scope;
        logic [HALF_W-1:0] field;
        assign in_scope = whole || (h == 1 ? (scope_i == SC_LEFT) : (scope_i == SC_RIGHT));
        assign field    = whole ? word_i[h*HALF_W +: HALF_W] : word_i[HALF_W-1:0];
        assign sel_o[h*HALF_W +: HALF_W]  = {HALF_W{in_scope}};
        assign mask_o[h*HALF_W +: HALF_W] = field & {HALF_W{in_scope}};
    end
endmodule

// File: rtl/ind_mask_update.sv
// Computes the next indicator value for a write operation.
// Operations outside load, set, clear and invert return the current value.
// Assumes mask_i is already limited to sel_i.
module ind_mask_update
    import ind_mask_pkg::*;
#(
    parameter int W = 36
) (
    input  ind_op_e      op_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] sel_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] nxt_o
);
    // Select the per-operation combination of current value and mask.
    always_comb begin
        unique case (op_i)
            OP_LOAD:  nxt_o = (cur_i & ~sel_i) | mask_i;
            OP_SET:   nxt_o = cur_i | mask_i;
            OP_CLEAR: nxt_o = cur_i & ~mask_i;
            OP_FLIP:  nxt_o = cur_i ^ mask_i;
            default:  nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/ind_mask_match.sv
// Evaluates the two match tests against the current indicators.
// Assumes mask_i is zero outside the selected scope.
module ind_mask_match #(
    parameter int W = 36
) (
    input  logic         want_ones_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] mask_i,
    output logic         ok_o
);
    logic [W-1:0] hits;

    // Mask ones that find a set indicator.
    assign hits = cur_i & mask_i;

    // On-test: every mask one is found set. Off-test: none is found set.
    assign ok_o = want_ones_i ? (hits == mask_i) : (hits == '0);
endmodule

// File: rtl/ind_mask_unit.sv
// Masked indicator register unit: holds the indicators and applies one
// command per cycle.
// Writes update the register at the clock edge. A test drives hit_q for
// exactly the following cycle.
// Assumes a synchronous active-low reset. Reserved codes act as no-ops.
module ind_mask_unit
    import ind_mask_pkg::*;
#(
    parameter int HALF_W = 18,
    localparam int W = 2 * HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [1:0]   cmd_scope,
    input  logic [W-1:0] cmd_word,
    output logic [W-1:0] ind_q,
    output logic         hit_q
);
    ind_op_e    op;
    ind_scope_e scope;
    logic [W-1:0] sel, mask, nxt;
    logic legal, is_test, is_write, ok;

    assign op    = ind_op_e'(cmd_op);
    assign scope = ind_scope_e'(cmd_scope);

    // Decode command class; reserved codes are never legal.
    assign legal    = cmd_valid && (scope != SC_RSVD) && (op != OP_RSV6) && (op != OP_RSV7);
    assign is_test  = (op == OP_T_ON) || (op == OP_T_OFF);
    assign is_write = legal && !is_test;

    ind_mask_place #(.HALF_W(HALF_W)) u_place (
        .scope_i (scope),
        .word_i  (cmd_word),
        .sel_o   (sel),
        .mask_o  (mask)
    );

    ind_mask_update #(.W(W)) u_update (
        .op_i   (op),
        .cur_i  (ind_q),
        .sel_i  (sel),
        .mask_i (mask),
        .nxt_o  (nxt)
    );

    ind_mask_match #(.W(W)) u_match (
        .want_ones_i (op == OP_T_ON),
        .cur_i       (ind_q),
        .mask_i      (mask),
        .ok_o        (ok)
    );

    // Indicator register: cleared by reset, written by legal write commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ind_q <= '0;
        else if (is_write)
            ind_q <= nxt;
    end

    // Test verdict: a one-cycle registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit_q <= 1'b0;
        else
            hit_q <= legal && is_test && ok;
    end
endmodule

// File: rtl/ind_mask_checker.sv
// Assertion checker for ind_mask_unit, attached with bind.
// Works only from the top-level ports.
module ind_mask_checker #(
    parameter int HALF_W = 18,
    localparam int W = 2 * HALF_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [2:0]   cmd_op,
    input logic [1:0]   cmd_scope,
    input logic [W-1:0] cmd_word,
    input logic [W-1:0] ind_q,
    input logic         hit_q
);
    logic rsv, test_cmd, zero_mask;

    // Recognise command classes straight from the port encodings.
    assign rsv       = cmd_valid && (cmd_op > 3'd5 || cmd_scope == 2'd3);
    assign test_cmd  = cmd_valid && !rsv && (cmd_op == 3'd4 || cmd_op == 3'd5);
    assign zero_mask = (cmd_scope == 2'd0) ? (cmd_word == '0) : (cmd_word[HALF_W-1:0] == '0);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (ind_q == '0) && !hit_q); // R1

    AST_SET_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rsv && cmd_op == 3'd1) |=> ((ind_q & $past(ind_q)) == $past(ind_q))); // R3

    AST_CLEAR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rsv && cmd_op == 3'd2) |=> ((ind_q & ~$past(ind_q)) == '0)); // R4

    AST_LEFT_KEEPS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_scope == 2'd1) |=> $stable(ind_q[HALF_W-1:0])); // R6

    AST_RIGHT_KEEPS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_scope == 2'd2) |=> $stable(ind_q[W-1:HALF_W])); // R6

    AST_ZERO_MASK_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (test_cmd && zero_mask) |=> hit_q); // R9

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        test_cmd |=> $stable(ind_q)); // R10

    AST_HIT_ONLY_AFTER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        !test_cmd |=> !hit_q); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(ind_q)); // R10

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |=> $stable(ind_q) && !hit_q); // R11
endmodule

bind ind_mask_unit ind_mask_checker #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/tb_ind_mask_unit.sv
`timescale 1ns/1ps
module tb_ind_mask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_scope = 2'd0;
    logic [35:0] cmd_word = '0;
    logic [35:0] ind_q;
    logic        hit_q;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";
    string req_q = "R1";
    logic [35:0] exp_ind = '0;
    logic        exp_hit = 1'b0;

    always #4 clk = ~clk;

    ind_mask_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_scope(cmd_scope), .cmd_word(cmd_word), .ind_q(ind_q), .hit_q(hit_q)
    );

    // Behavioural per-position reference: whether position p is in scope.
    function automatic bit in_scope(input int p, input logic [1:0] sc);
        return sc == 2'd0 || (sc == 2'd1 && p < 18) || (sc == 2'd2 && p >= 18);
    endfunction

    // Mask bit for position p (p = 0 is vector bit 35).
    function automatic logic mbit(input int p, input logic [1:0] sc, input logic [35:0] w);
        return (sc == 2'd0) ? w[35-p] : w[17-(p % 18)];
    endfunction

    function automatic logic [35:0] model_next(input logic [35:0] cur, input logic [2:0] op,
                                               input logic [1:0] sc, input logic [35:0] w);
        logic [35:0] r = cur;
        if (sc == 2'd3 || op > 3'd3) return cur;
        for (int p = 0; p < 36; p++) begin
            if (!in_scope(p, sc)) continue;
            case (op)
                3'd0: r[35-p] = mbit(p, sc, w);
                3'd1: if (mbit(p, sc, w)) r[35-p] = 1'b1;
                3'd2: if (mbit(p, sc, w)) r[35-p] = 1'b0;
                default: if (mbit(p, sc, w)) r[35-p] = ~cur[35-p];
            endcase
        end
        return r;
    endfunction

    function automatic logic model_hit(input logic [35:0] cur, input logic [2:0] op,
                                       input logic [1:0] sc, input logic [35:0] w);
        logic good = 1'b1;
        if (sc == 2'd3 || (op != 3'd4 && op != 3'd5)) return 1'b0;
        for (int p = 0; p < 36; p++)
            if (in_scope(p, sc) && mbit(p, sc, w) && (cur[35-p] != (op == 3'd4)))
                good = 1'b0;
        return good;
    endfunction

    // Reference update at each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        req_q   <= rst_n ? cur_req : "R1";
        if (!rst_n) begin
            exp_ind <= '0;
            exp_hit <= 1'b0;
        end else if (cmd_valid) begin
            exp_ind <= model_next(exp_ind, cmd_op, cmd_scope, cmd_word);
            exp_hit <= model_hit(exp_ind, cmd_op, cmd_scope, cmd_word);
        end else begin
            exp_hit <= 1'b0;
        end
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (ind_q !== exp_ind || hit_q !== exp_hit) begin
                errors++;
                $display("FAIL %s: ind_q=%h hit_q=%b expected ind_q=%h hit_q=%b",
                         req_q, ind_q, hit_q, exp_ind, exp_hit);
            end
        end
    end

    task automatic cmd(input logic [2:0] op, input logic [1:0] sc, input logic [35:0] w,
                       input string r);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_scope = sc; cmd_word = w; cur_req = r;
    endtask

    task automatic idle(input string r);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_word = 36'hFFFFFFFFF; cur_req = r;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmd(3'd0, 2'd0, 36'h0F0F0F0F0, "R2");       // whole load
        cmd(3'd1, 2'd0, 36'h800000001, "R3");       // set both ends
        cmd(3'd2, 2'd0, 36'h00F000000, "R4");       // clear middle
        cmd(3'd3, 2'd0, 36'hFFFF00000, "R5");       // invert upper
        cmd(3'd0, 2'd1, 36'h00003FFFF, "R6");       // left half load all ones
        cmd(3'd0, 2'd2, 36'h000020001, "R6");       // right half load, bit order
        cmd(3'd1, 2'd2, 36'hFFFC00000, "R6");       // upper word bits ignored in half form
        cmd(3'd2, 2'd1, 36'h000020000, "R6");       // clear position 0 only
        cmd(3'd3, 2'd2, 36'h00000000F, "R5");       // half invert
        cmd(3'd4, 2'd1, 36'h00001FFFF, "R7");       // on-test true
        idle("R10");
        cmd(3'd4, 2'd1, 36'h00003FFFF, "R7");       // on-test false (pos 0 clear)
        cmd(3'd5, 2'd2, 36'h000010000, "R8");       // off-test
        cmd(3'd5, 2'd0, 36'h800000000, "R8");
        cmd(3'd4, 2'd0, 36'h000000000, "R9");       // zero mask on-test
        cmd(3'd5, 2'd2, 36'hFFFFC0000, "R9");       // zero half mask off-test
        cmd(3'd6, 2'd0, 36'h123456789, "R11");
        cmd(3'd7, 2'd1, 36'h3FFFF, "R11");
        cmd(3'd0, 2'd3, 36'h000000000, "R11");
        cmd(3'd4, 2'd3, 36'h000000000, "R11");
        idle("R10");
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            logic [1:0] sc = 2'($urandom_range(0, 3));
            logic [35:0] w = {4'($urandom), 32'($urandom)};
            if (i % 7 == 0) w = '0;
            if (i % 11 == 0) idle("R10");
            else cmd(op, sc, w, op > 3'd5 || sc == 2'd3 ? "R11" : op >= 3'd4 ? "R7" : "R3");
        end
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b1; cmd_op = 3'd0; cmd_word = '1; cur_req = "R1";
        idle("R1");
        rst_n = 1'b1;
        idle("R10");
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule